// File: doc/BRIEF.md
# 4:2:2 Pixel Output Formatter

This block sits between an upstream rate converter and a video output port. The converter hands it one pixel at a time. Each pixel comes with a valid strobe, a luma byte, the co-sited Cb and Cr bytes, a line-start marker and an active-region flag. The strobe is irregular: the converter paces samples, so single-cycle gaps can appear anywhere in a line. The formatter keeps a Cb/Cr phase that tracks which chroma component belongs to each pixel. It presents the stream in one of two output formats, chosen by a mode input.

In the two-bus format, luma and chroma leave on separate byte buses. Chroma alternates between Cb and Cr on successive valid pixels. Blanking pixels are still flagged valid, and they carry fixed black levels. In the single-bus format, only active pixels are sent. Each one becomes two consecutive bytes, chroma first and luma second. The active output is held high for as long as this format is selected. All outputs come from registers.

Top module: `pxfmt_top`

## Requirements
- R1: While reset is applied and on the first cycle after it, outValid and outActive are 0.
- R2: With mode8=0, a pixel presented with inValid=1 appears one cycle later with outValid=1, outActive equal to its inActive, and (when active) outLuma equal to its inLuma.
- R3: The chroma phase is 0 on a pixel accepted with inLineStart=1, and it flips after each accepted pixel. Gaps do not advance it. Phase 0 selects inCb and phase 1 selects inCr, so the order is Cb, Cr, Cb, ... from the line start.
- R4: With mode8=0, a valid pixel with inActive=0 is output with outValid=1, outActive=0, outLuma=0x10 and outChroma=0x80.
- R5: With mode8=1, an accepted active pixel yields two bytes on outLuma, each with outValid=1. The cycle after acceptance carries the phase-selected chroma byte, and the next cycle carries that pixel's luma. outChroma is 0x80 on both.
- R6: With mode8=1, outActive is 1 on every cycle after the first clock edge with mode8 selected.
- R7: With mode8=1, a valid pixel with inActive=0 produces no outValid and does not advance the chroma phase.
- R8: With mode8=1, a valid pixel arriving on the cycle when a luma byte is being sent is dropped. It does not advance the phase, and it does not apply its line-start marker.
- R9: When no pixel is emitted (no input in mode 0; no accepted pixel and no pending luma in mode 1), outValid is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode8 | input | 1 | 1 selects the single-bus format, 0 the two-bus format |
| inValid | input | 1 | Pixel strobe from the rate converter |
| inActive | input | 1 | Pixel lies in the active region |
| inLineStart | input | 1 | Pixel is the first active pixel of a line |
| inLuma | input | 8 | Luma byte |
| inCb | input | 8 | Co-sited Cb byte |
| inCr | input | 8 | Co-sited Cr byte |
| outValid | output | 1 | Output byte(s) valid |
| outActive | output | 1 | Active-region flag for the output |
| outLuma | output | 8 | Luma bus; in the single-bus format it carries the multiplexed bytes |
| outChroma | output | 8 | Chroma bus; held at 0x80 in the single-bus format |

## Verification
A wrong chroma phase shows up on the first chroma byte after the corrupted pixel, one or two cycles later. Cb and Cr swap, and every later byte up to the next line start is swapped as well. A stuck or spurious pending-luma state is visible within two cycles, either as an extra valid byte or as a missing luma byte. It also shows up as a new pixel accepted where it should have been dropped. A blanking path that passes real data through is seen on the first valid pixel with the active flag low, because its luma or chroma value will differ from the black levels.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  typedef struct packed {
    logic emit16;
    logic blank16;
    logic emitC8;
    logic emitY8;
    logic selCr;
    logic activeOut;
  } fmtStrobes_t;
endpackage

// File: rtl/pxfmt_ctrl.sv
module pxfmt_ctrl
  import pxfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        mode8,
  input  logic        inValid,
  input  logic        inActive,
  input  logic        inLineStart,
  output fmtStrobes_t strobes
);
  logic phase;
  logic pending;
  logic curPhase;
  logic accept16;
  logic accept8;
  logic acceptAny;

  always_comb begin
    accept16  = !mode8 && inValid;
    accept8   = mode8 && inValid && inActive && !pending;
    acceptAny = accept16 || accept8;
    curPhase  = inLineStart ? 1'b0 : phase;

    strobes.emit16    = accept16;
    strobes.blank16   = accept16 && !inActive;
    strobes.emitC8    = accept8;
    strobes.emitY8    = pending && mode8;
    strobes.selCr     = curPhase;
    strobes.activeOut = mode8 || inActive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      pending <= 1'b0;
    end else begin
      pending <= accept8;
      if (acceptAny) phase <= !curPhase;
    end
  end

  // R3: a pixel taken with a line-start marker leaves the phase at Cr for the next one
  p_linestart_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acceptAny && inLineStart)) |-> phase);

  // R3: gaps leave the phase untouched
  p_gap_holds_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acceptAny)) |-> $stable(phase));
endmodule

// File: rtl/pxfmt_dp.sv
module pxfmt_dp
  import pxfmt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] BLANK_Y = 8'h10,
  parameter logic [DATA_W-1:0] BLANK_C = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  fmtStrobes_t       strobes,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outValid,
  output logic              outActive,
  output logic [DATA_W-1:0] outLuma,
  output logic [DATA_W-1:0] outChroma
);
  logic [DATA_W-1:0] lumaHold;
  logic [DATA_W-1:0] chromaSel;

  always_comb chromaSel = strobes.selCr ? inCr : inCb;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outActive <= 1'b0;
      outLuma   <= BLANK_Y;
      outChroma <= BLANK_C;
      lumaHold  <= BLANK_Y;
    end else begin
      outValid  <= strobes.emit16 || strobes.emitC8 || strobes.emitY8;
      outActive <= strobes.activeOut;
      if (strobes.emit16) begin
        outLuma   <= strobes.blank16 ? BLANK_Y : inLuma;
        outChroma <= strobes.blank16 ? BLANK_C : chromaSel;
      end else if (strobes.emitC8) begin
        outLuma   <= chromaSel;
        outChroma <= BLANK_C;
        lumaHold  <= inLuma;
      end else if (strobes.emitY8) begin
        outLuma   <= lumaHold;
        outChroma <= BLANK_C;
      end
    end
  end

  // R5: at most one byte source per cycle
  p_one_source_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.emit16, strobes.emitC8, strobes.emitY8}));

  // R5: a luma byte is only sent right after its chroma byte
  p_luma_after_chroma_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && strobes.emitY8) |-> $past(strobes.emitC8));

  // R4: valid output outside the active region carries black levels
  p_blank_levels_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outActive) |-> (outLuma == BLANK_Y && outChroma == BLANK_C));
endmodule

// File: rtl/pxfmt_top.sv
module pxfmt_top
  import pxfmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode8,
  input  logic              inValid,
  input  logic              inActive,
  input  logic              inLineStart,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outValid,
  output logic              outActive,
  output logic [DATA_W-1:0] outLuma,
  output logic [DATA_W-1:0] outChroma
);
  localparam logic [DATA_W-1:0] BlankY = DATA_W'(16) << (DATA_W - 8);
  localparam logic [DATA_W-1:0] BlankC = DATA_W'(1) << (DATA_W - 1);

  fmtStrobes_t strobes;

  pxfmt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode8(mode8), .inValid(inValid),
    .inActive(inActive), .inLineStart(inLineStart), .strobes(strobes)
  );

  pxfmt_dp #(.DATA_W(DATA_W), .BLANK_Y(BlankY), .BLANK_C(BlankC)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .inLuma(inLuma),
    .inCb(inCb), .inCr(inCr), .outValid(outValid), .outActive(outActive),
    .outLuma(outLuma), .outChroma(outChroma)
  );

  // R6: single-bus format keeps the active flag high
  p_active_in_mode8_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode8)) |-> outActive);

  // R1: reset clears the valid flag
  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !outActive));
endmodule

// File: tb/pxfmt_top_bench.sv
module pxfmt_top_bench;
  logic       clk = 1'b0;
  logic       rst, mode8, inValid, inActive, inLineStart;
  logic [7:0] inLuma, inCb, inCr;
  logic       outValid, outActive;
  logic [7:0] outLuma, outChroma;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic       bPhase, bPend;
  logic [7:0] bPendY;
  logic       expV, expA;
  logic [7:0] expL, expC;

  always #5 clk = ~clk;

  pxfmt_top u_pxfmt_top (
    .clk(clk), .rst(rst), .mode8(mode8), .inValid(inValid),
    .inActive(inActive), .inLineStart(inLineStart), .inLuma(inLuma),
    .inCb(inCb), .inCr(inCr), .outValid(outValid), .outActive(outActive),
    .outLuma(outLuma), .outChroma(outChroma)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1; mode8 = m; inValid = 0; inActive = 0; inLineStart = 0;
    inLuma = 0; inCb = 0; inCr = 0;
    @(negedge clk);
    chk("R1 valid in reset", outValid, 0);
    chk("R1 active in reset", outActive, 0);
    rst = 0;
    bPhase = 0; bPend = 0; bPendY = 0;
  endtask

  // drive one pixel, compute expectation, check after the edge
  task automatic step(input logic v, input logic a, input logic ls,
                      input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr);
    logic ph;
    inValid = v; inActive = a; inLineStart = ls; inLuma = y; inCb = cb; inCr = cr;
    ph = ls ? 1'b0 : bPhase;
    expL = 8'h00; expC = 8'h00;
    if (!mode8) begin
      expA = a;
      expV = v;
      if (v) begin
        expL = a ? y : 8'h10;
        expC = a ? (ph ? cr : cb) : 8'h80;
        bPhase = !ph;
      end
    end else begin
      expA = 1'b1;
      if (bPend) begin
        expV = 1; expL = bPendY; expC = 8'h80; bPend = 0;
      end else if (v && a) begin
        expV = 1; expL = ph ? cr : cb; expC = 8'h80;
        bPendY = y; bPend = 1; bPhase = !ph;
      end else begin
        expV = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (mode8) begin
      chk("R6 active", outActive, expA);
      chk(v && !a ? "R7 valid" : (expV ? "R5 valid" : "R8/R9 valid"), outValid, expV);
      if (expV) begin
        chk("R5 byte", outLuma, expL);
        chk("R5 chroma idle", outChroma, expC);
      end
    end else begin
      chk(v ? "R2 valid" : "R9 valid", outValid, expV);
      chk("R2 active", outActive, expA);
      if (expV) begin
        chk(a ? "R2 luma" : "R4 luma", outLuma, expL);
        chk(a ? "R3 chroma" : "R4 chroma", outChroma, expC);
      end
    end
  endtask

  initial begin
    rst = 1; mode8 = 0; inValid = 0; inActive = 0; inLineStart = 0;
    inLuma = 0; inCb = 0; inCr = 0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int line = 0; line < 6; line++) begin
        int st = 3 + line;
        int gm = 2 + (line % 3);
        for (int i = 0; i < 28; i++) begin
          logic a, v, ls;
          a  = (i >= st) && (i < st + 16);
          v  = (i == st) || ((i % gm) != (gm - 1));
          ls = (i == st);
          // line 5 forces back-to-back pixels to exercise dropping (R8)
          if (line == 5) v = 1'b1;
          step(v, a, ls, 8'(i * 7 + line), 8'(8'h40 + i), 8'(8'hC0 - i));
        end
      end
    end
    do_reset(1'b0);
    step(0, 1, 0, 8'h55, 8'h11, 8'h22); // R9 idle after reset
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule